// File: doc/BRIEF.md
# Complex Fixed-Point Precision Converter

This block changes the numeric format of a stream of complex samples. Each sample arrives as one packed word that holds a real part and an imaginary part. Both parts are two's-complement fixed-point numbers that share one input format, set by a bit width and a count of fractional bits. The block converts both parts in parallel to an output format, set by its own width and fractional-bit count. It never adds fractional bits. It may drop fractional bits, either by truncation or by rounding, and it may narrow the integer range, either by saturating or by wrapping on overflow.

The block is a fixed-latency pipeline. The `LATENCY` parameter sets the number of register stages between input and output, with a default of 2. A valid flag travels with each sample. There is no ready signal and so no back-pressure: the block takes a sample on every cycle that `in_valid` is high, and the consumer must take every sample on the cycle that `out_valid` is high. When `LATENCY` is 2 or more, the first register sits after the rounding adder and the remaining registers sit after the range limiter. With the default parameters (8-bit parts, no fractional bits, round, wrap) the output equals the input, delayed by the pipeline.

Top module: `cfx_precision_conv`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly `LATENCY` clock edges, with no sample lost or repeated. A synchronous active-high `rst` clears every stage, so after an edge with `rst` high, `out_valid` is 0 and `out_data` is all zeros.
- R2: The real part occupies bits [2*IN_W-1:IN_W] of `in_data` and the imaginary part occupies bits [IN_W-1:0]. The output uses the same layout with `OUT_W`-bit halves.
- R3: In truncate mode (`QUANT` = `CFX_TRUNC`), dropping D = IN_BP - OUT_BP fractional bits gives floor(x / 2^D), which rounds toward negative infinity.
- R4: In round mode (`QUANT` = `CFX_ROUND`), the block adds half of one output LSB before it drops bits: the result is floor((x + 2^(D-1)) / 2^D). Ties therefore go toward positive infinity. A carry out of the top bit is handled by the overflow stage.
- R5: In saturate mode (`OVF` = `CFX_SAT`), a result outside the output range becomes 2^(OUT_W-1)-1 if it is positive and -2^(OUT_W-1) if it is negative.
- R6: In wrap mode (`OVF` = `CFX_WRAP`), the output keeps the low `OUT_W` bits of the quantized result.
- R7: The two parts are converted independently: the value of one part, including overflow, never changes the other part's result.
- R8: A quantized result that fits in `OUT_W` bits is passed through exactly in both overflow modes, with its sign kept.
- R9: Each stage loads new data only on a cycle that carries a valid sample. While `out_valid` is low, `out_data` holds the last valid result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a sample on `in_data` this cycle |
| in_data | input | 2*IN_W | Packed complex input, real part in the upper half |
| out_valid | output | 1 | Marks a converted sample on `out_data` |
| out_data | output | 2*OUT_W | Packed complex output, real part in the upper half |

## Verification
The hardest case to reach from the ports is a rounding carry out of the largest positive input. This carry creates an overflow that does not exist before rounding, and the saturate and wrap modes must then give clamped and sign-flipped results. The bench uses a small format, 6-bit Q2.4 in and 4-bit Q2.2 out. It drives every pair of real and imaginary codes, so this carry appears next to every value of the other part. Four copies of the block cover all four mode pairs and three latencies. Idle cycles are inserted at regular points in the sweep so that data hold is checked while the pipeline is partly full.

// File: rtl/cfx_pkg.sv
package cfx_pkg;

  // Treatment of dropped fractional bits
  typedef enum logic {
    CFX_TRUNC = 1'b0,
    CFX_ROUND = 1'b1
  } cfx_quant_e;

  // Treatment of results outside the output range
  typedef enum logic {
    CFX_WRAP = 1'b0,
    CFX_SAT  = 1'b1
  } cfx_ovf_e;

endpackage

// File: rtl/cfx_round.sv
module cfx_round
  import cfx_pkg::*;
#(
  parameter int         IN_W  = 8,
  parameter int         DROP  = 0,
  parameter cfx_quant_e QUANT = CFX_ROUND
) (
  input  logic [IN_W-1:0]    din,
  output logic [IN_W-DROP:0] dout
);

  localparam int HALF_I = (DROP > 0) ? (1 << (DROP - 1)) : 0;
  localparam int STEP_I = 1 << DROP;
  localparam logic [IN_W:0] BIAS =
    (QUANT == CFX_ROUND) ? (IN_W + 1)'(HALF_I) : '0;

  // One guard bit above the sign keeps the rounding carry
  logic [IN_W:0] ext;
  logic [IN_W:0] sum;

  always_comb begin
    ext = {din[IN_W-1], din};
    sum = ext + BIAS;
  end

  assign dout = sum[IN_W:DROP];

  // Relate the kept value back to the input at full scale
  logic signed [IN_W+1:0] scaled;
  logic signed [IN_W+1:0] err_in;
  logic signed [IN_W+1:0] err_sum;

  always_comb begin
    scaled  = (IN_W + 2)'($signed(dout)) <<< DROP;
    err_in  = $signed({ext[IN_W], ext}) - scaled;
    err_sum = $signed({sum[IN_W], sum}) - scaled;
    // R3: the kept value is the floor of the (biased) input
    a_r3_floor_step: assert (err_sum >= 0 && err_sum < STEP_I);
    if (QUANT == CFX_ROUND && DROP > 0) begin
      // R4: error lies in [-half, +half) of an output LSB
      a_r4_half_up: assert (err_in >= -HALF_I && err_in < HALF_I);
    end
  end

endmodule

// File: rtl/cfx_clip.sv
module cfx_clip
  import cfx_pkg::*;
#(
  parameter int       IN_W  = 9,
  parameter int       OUT_W = 8,
  parameter cfx_ovf_e OVF   = CFX_WRAP
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);

  if (OUT_W >= IN_W) begin : g_widen
    // Output range covers the input: sign-extend only
    assign dout = OUT_W'($signed(din));
  end else begin : g_narrow
    localparam logic [OUT_W-1:0] MAX_V = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MIN_V = {1'b1, {(OUT_W-1){1'b0}}};

    logic [IN_W-OUT_W:0] top;
    logic                ovf;

    always_comb begin
      top = din[IN_W-1:OUT_W-1];
      ovf = !((&top) || !(|top));
      if (ovf && OVF == CFX_SAT) begin
        dout = din[IN_W-1] ? MIN_V : MAX_V;
      end else begin
        dout = din[OUT_W-1:0];
      end
    end

    always_comb begin
      if (!ovf) begin
        // R8: in-range values come through unchanged
        a_r8_exact_in_range: assert (IN_W'($signed(dout)) == din);
      end
      if (OVF == CFX_SAT) begin
        // R5: clamping never flips the sign
        a_r5_sign_kept: assert (dout[OUT_W-1] == din[IN_W-1]);
      end
    end
  end

endmodule

// File: rtl/cfx_stage.sv
module cfx_stage #(
  parameter int W     = 16,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);

  if (DEPTH == 0) begin : g_wire
    assign vld_o = vld_i;
    assign dat_o = dat_i;
  end else begin : g_regs
    logic         v [DEPTH+1];
    logic [W-1:0] d [DEPTH+1];

    assign v[0] = vld_i;
    assign d[0] = dat_i;

    for (genvar g = 1; g <= DEPTH; g++) begin : g_st
      always_ff @(posedge clk) begin
        if (rst) begin
          v[g] <= 1'b0;
          d[g] <= '0;
        end else begin
          v[g] <= v[g-1];
          if (v[g-1]) begin
            d[g] <= d[g-1];
          end
        end
      end
    end

    assign vld_o = v[DEPTH];
    assign dat_o = d[DEPTH];

    // R9: an idle input cycle leaves the first register untouched
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
      !vld_i |=> $stable(d[1]));

    // R1: the reset leaves no valid sample behind
    a_r1_cleared_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !vld_o);
  end

endmodule

// File: rtl/cfx_precision_conv.sv
module cfx_precision_conv
  import cfx_pkg::*;
#(
  parameter int         IN_W    = 8,
  parameter int         IN_BP   = 0,
  parameter int         OUT_W   = 8,
  parameter int         OUT_BP  = 0,
  parameter cfx_quant_e QUANT   = CFX_ROUND,
  parameter cfx_ovf_e   OVF     = CFX_WRAP,
  parameter int         LATENCY = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [2*IN_W-1:0]    in_data,
  output logic                 out_valid,
  output logic [2*OUT_W-1:0]   out_data
);

  localparam int DROP  = IN_BP - OUT_BP;
  localparam int RW    = IN_W + 1 - DROP;
  localparam int PRE   = (LATENCY >= 2) ? 1 : 0;
  localparam int POST  = LATENCY - PRE;
  localparam int NCOMP = 2;

  logic [NCOMP*RW-1:0]    rnd_pk;
  logic [NCOMP*RW-1:0]    rs_pk;
  logic                   rs_vld;
  logic [NCOMP*OUT_W-1:0] cl_pk;

  // Component 1 = real (upper half), component 0 = imaginary (lower half)
  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    cfx_round #(
      .IN_W (IN_W),
      .DROP (DROP),
      .QUANT(QUANT)
    ) i_round (
      .din (in_data[c*IN_W +: IN_W]),
      .dout(rnd_pk[c*RW +: RW])
    );

    cfx_clip #(
      .IN_W (RW),
      .OUT_W(OUT_W),
      .OVF  (OVF)
    ) i_clip (
      .din (rs_pk[c*RW +: RW]),
      .dout(cl_pk[c*OUT_W +: OUT_W])
    );
  end

  // Register after the rounding adder when latency allows
  cfx_stage #(
    .W    (NCOMP * RW),
    .DEPTH(PRE)
  ) i_pre (
    .clk  (clk),
    .rst  (rst),
    .vld_i(in_valid),
    .dat_i(rnd_pk),
    .vld_o(rs_vld),
    .dat_o(rs_pk)
  );

  // Remaining stages after the range limiter
  cfx_stage #(
    .W    (NCOMP * OUT_W),
    .DEPTH(POST)
  ) i_post (
    .clk  (clk),
    .rst  (rst),
    .vld_i(rs_vld),
    .dat_i(cl_pk),
    .vld_o(out_valid),
    .dat_o(out_data)
  );

endmodule

// File: tb/test_cfx_precision_conv.sv
module test_cfx_precision_conv;
  import cfx_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int TIW  = 6;
  localparam int TIBP = 4;
  localparam int TOW  = 4;
  localparam int TOBP = 2;
  localparam int NV   = 1 << (2 * TIW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2*TIW-1:0] in_data = '0;

  logic             ov [4];
  logic [2*TOW-1:0] od [4];

  // Modes per copy: 0 round/sat L2, 1 trunc/wrap L2, 2 round/wrap L3, 3 trunc/sat L1
  bit rnd_k [4] = '{1'b1, 1'b0, 1'b1, 1'b0};
  bit sat_k [4] = '{1'b1, 1'b0, 1'b0, 1'b1};
  int lat_k [4] = '{2, 2, 3, 1};

  int vectors = 0;
  int fails = 0;
  bit scoring = 1'b0;
  int nexp [4] = '{0, 0, 0, 0};
  bit have_last [4] = '{1'b0, 1'b0, 1'b0, 1'b0};
  logic [2*TOW-1:0] last [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfx_precision_conv #(.IN_W(TIW), .IN_BP(TIBP), .OUT_W(TOW), .OUT_BP(TOBP),
    .QUANT(CFX_ROUND), .OVF(CFX_SAT), .LATENCY(2)) i_cfx_precision_conv (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov[0]), .out_data(od[0]));

  cfx_precision_conv #(.IN_W(TIW), .IN_BP(TIBP), .OUT_W(TOW), .OUT_BP(TOBP),
    .QUANT(CFX_TRUNC), .OVF(CFX_WRAP), .LATENCY(2)) i_cfx_precision_conv_tw (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov[1]), .out_data(od[1]));

  cfx_precision_conv #(.IN_W(TIW), .IN_BP(TIBP), .OUT_W(TOW), .OUT_BP(TOBP),
    .QUANT(CFX_ROUND), .OVF(CFX_WRAP), .LATENCY(3)) i_cfx_precision_conv_rw (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov[2]), .out_data(od[2]));

  cfx_precision_conv #(.IN_W(TIW), .IN_BP(TIBP), .OUT_W(TOW), .OUT_BP(TOBP),
    .QUANT(CFX_TRUNC), .OVF(CFX_SAT), .LATENCY(1)) i_cfx_precision_conv_ts (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov[3]), .out_data(od[3]));

  // Unlimited-range quantized value of a 6-bit code (2 bits dropped)
  function automatic int quant(logic [TIW-1:0] code, bit rnd);
    int x;
    x = int'($signed(code));
    if (rnd) x = x + 2;
    return x >>> 2;
  endfunction

  function automatic logic [TOW-1:0] model(logic [TIW-1:0] code, bit rnd, bit sat);
    int y;
    y = quant(code, rnd);
    if (sat) begin
      if (y > 7) y = 7;
      if (y < -8) y = -8;
    end
    return y[TOW-1:0];
  endfunction

  function automatic bit overflows(logic [TIW-1:0] code, bit rnd);
    int y;
    y = quant(code, rnd);
    return (y > 7) || (y < -8);
  endfunction

  task automatic check(string tag, int k, logic [2*TOW-1:0] act, logic [2*TOW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s copy %0d actual=%h expected=%h", tag, k, act, exp);
    end
  endtask

  task automatic score(int k);
    logic [2*TIW-1:0] v;
    logic [2*TOW-1:0] e;
    string tag;
    if (!scoring) return;
    if (ov[k]) begin
      v = nexp[k][2*TIW-1:0];
      e = {model(v[2*TIW-1:TIW], rnd_k[k], sat_k[k]),
           model(v[TIW-1:0], rnd_k[k], sat_k[k])};
      if (overflows(v[2*TIW-1:TIW], rnd_k[k]) || overflows(v[TIW-1:0], rnd_k[k]))
        tag = sat_k[k] ? "R5 sweep" : "R6 sweep";
      else
        tag = rnd_k[k] ? "R4 sweep" : "R3 sweep";
      check(tag, k, od[k], e);
      nexp[k]++;
      last[k] = od[k];
      have_last[k] = 1'b1;
    end else if (have_last[k]) begin
      check("R9 hold while idle", k, od[k], last[k]);
    end
  endtask

  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) score(k);
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // Single directed sample, then read the held outputs of all copies
  task automatic one_shot(logic [TIW-1:0] re, logic [TIW-1:0] im);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = {re, im};
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_all(string tag, logic [TIW-1:0] re, logic [TIW-1:0] im);
    for (int k = 0; k < 4; k++)
      check(tag, k, od[k], {model(re, rnd_k[k], sat_k[k]), model(im, rnd_k[k], sat_k[k])});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) check("R1 reset state", k, {ov[k], od[k]}, '0);
    rst = 1'b0;

    // R1: latency of a single sample
    @(negedge clk);
    in_valid = 1'b1;
    in_data = 12'h041;
    @(negedge clk);
    in_valid = 1'b0;
    for (int j = 1; j <= 4; j++) begin
      for (int k = 0; k < 4; k++)
        check("R1 latency", k, {7'd0, ov[k]}, {7'd0, (j == lat_k[k])});
      @(negedge clk);
    end

    // Exhaustive sweep of both components with periodic idle cycles
    scoring = 1'b1;
    begin
      int i = 0;
      int c = 0;
      while (i < NV) begin
        @(negedge clk);
        if (c % 7 == 6) begin
          in_valid = 1'b0;
        end else begin
          in_valid = 1'b1;
          in_data = i[2*TIW-1:0];
          i++;
        end
        c++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
    scoring = 1'b0;
    for (int k = 0; k < 4; k++)
      check("R1 sample count", k, nexp[k][2*TOW-1:0], NV[2*TOW-1:0]);

    // R2: +1.0 real, -1.0 imaginary land in their halves
    one_shot(6'b010000, 6'b110000);
    for (int k = 0; k < 4; k++) check("R2 layout", k, od[k], 8'b0100_1100);

    // R4 and R3: ties at +0.125 and -0.125
    one_shot(6'b000010, 6'b111110);
    check("R4 tie up", 0, od[0], 8'b0001_0000);
    check("R3 floor", 1, od[1], 8'b0000_1111);
    expect_all("R4 R3 ties", 6'b000010, 6'b111110);

    // R7: rounding carry overflow in real must not touch imaginary
    one_shot(6'b011111, 6'b000000);
    check("R7 R5 sat carry", 0, od[0], 8'b0111_0000);
    check("R7 R6 wrap carry", 2, od[2], 8'b1000_0000);
    check("R6 trunc no carry", 1, od[1], 8'b0111_0000);

    // R8: most negative input passes exactly in every mode
    one_shot(6'b100000, 6'b011011);
    for (int k = 0; k < 4; k++) check("R8 exact", k, od[k][7:4], 4'b1000);
    expect_all("R8 R5 R6 mixed", 6'b100000, 6'b011011);

    // R1: synchronous reset with a full pipeline
    @(negedge clk);
    in_valid = 1'b1;
    in_data = 12'h7FF;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 4; k++) check("R1 mid reset", k, {ov[k], od[k]}, '0);
    rst = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);

    summary();
  end

endmodule